// File: doc/BRIEF.md
# Signed Integer to Floating-Point Converter

This block turns a signed two's-complement integer into an IEEE 754 binary floating-point number. The source is either 32 or 64 bits wide, and the result is half, single or double precision. A one-bit source-size select and a two-bit destination-type field choose the sizes. Only four size pairings are accepted. Any other pairing raises an undefined-encoding output, and the destination passes through unchanged.

The rounding direction comes from a two-bit control input. The converted value lands in the low element of a 128-bit destination word. A merge control decides the bits above that element: they are either copied from the previous destination word or cleared. Inexact and overflow status flags come out alongside the result.

The conversion is one combinational stage followed by output registers. The outputs load only on a cycle where `in_valid` is high, and `out_valid` is `in_valid` delayed by one clock.

Top module: `sint_fp_cvt`

## Requirements
- R1: With `src_is64`=0 only `src_int[31:0]` is converted, bit 31 is the sign and bits 63:32 have no effect. With `src_is64`=1 all 64 bits are converted, with bit 63 as the sign.
- R2: `dst_type` encodes 00 = single (32-bit), 01 = double (64-bit) and 11 = half (16-bit). The legal pairings are 32→half, 32→double, 64→half and 64→single. Any other pairing sets `out_undef`=1, makes `out_result` equal `old_dst`, and clears both flags.
- R3: Exactly representable values convert exactly. Zero gives +0.0. The most negative source value converts to minus two to the source width minus one.
- R4: `rnd_mode` encodes 00 = nearest-even, 01 = toward +infinity, 10 = toward −infinity and 11 = toward zero. The rounding uses that mode.
- R5: `flag_inexact` is 1 when the rounded result differs from the source value, and 0 otherwise.
- R6: `flag_overflow` is 1 when the value, rounded with an unbounded exponent, exceeds 65504 in magnitude, and `flag_inexact` is then also 1. The result is then ±infinity for nearest-even, or when the rounding direction points away from zero. Otherwise it is the largest finite magnitude with the source sign.
- R7: The value occupies bits [w-1:0] of `out_result`, where w is 16, 32 or 64. The bits above it equal `old_dst` when `merge_en`=1 and are zero when `merge_en`=0.
- R8: The outputs take the values computed from the inputs sampled at a rising edge where `in_valid`=1. `out_valid` equals `in_valid` from the previous edge. When `in_valid`=0, `out_result`, `out_undef` and both flags hold their values.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid; loads the output registers |
| src_is64 | input | 1 | Source size: 0 = 32-bit, 1 = 64-bit |
| dst_type | input | 2 | Destination format code |
| rnd_mode | input | 2 | Rounding direction code |
| merge_en | input | 1 | 1 = keep upper destination bits, 0 = zero them |
| src_int | input | 64 | Signed integer operand |
| old_dst | input | 128 | Previous destination contents |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 128 | Merged destination word |
| out_undef | output | 1 | Unsupported size pairing |
| flag_inexact | output | 1 | Result was rounded |
| flag_overflow | output | 1 | Result exceeded the largest finite value |

## Verification
Every result, flag and the undefined-encoding output is due exactly one rising edge after the cycle in which `in_valid` is high. No result needs more than that single register stage.

The bench changes inputs on the falling edge and lets one rising edge pass. It samples on the following falling edge, so each check reads the register loaded by its own stimulus. Hold behaviour is checked the same way: the bench drives new operands with `in_valid` low and, one falling edge later, confirms the previous word is still there.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int SRC_W = 64;
  localparam int DST_W = 128;
  localparam int NFMT  = 3;

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_BAD = 2'b10,
    FMT_HLF = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_PINF = 2'b01,
    RM_NINF = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  // index of each format in the rounder generate array
  function automatic int fmt_exp_w(input int idx);
    return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
  endfunction

  function automatic int fmt_man_w(input int idx);
    return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
  endfunction
endpackage

// File: rtl/cvt_decode.sv
module cvt_decode
  import cvt_pkg::*;
(
  input  logic       src_is64,
  input  logic [1:0] dst_type,
  output logic       legal,
  output logic [1:0] fmt_idx,
  output logic [6:0] fmt_width
);
  always_comb begin
    legal     = 1'b0;
    fmt_idx   = 2'd0;
    fmt_width = 7'd16;
    unique case (fmt_e'(dst_type))
      FMT_HLF: begin legal = 1'b1;      fmt_idx = 2'd0; fmt_width = 7'd16; end
      FMT_SGL: begin legal = src_is64;  fmt_idx = 2'd1; fmt_width = 7'd32; end
      FMT_DBL: begin legal = !src_is64; fmt_idx = 2'd2; fmt_width = 7'd64; end
      default: begin legal = 1'b0;      fmt_idx = 2'd0; fmt_width = 7'd16; end
    endcase
  end
endmodule

// File: rtl/cvt_normalize.sv
module cvt_normalize
  import cvt_pkg::*;
#(
  parameter int W = SRC_W,
  localparam int LW = $clog2(W)
) (
  input  logic          src_is64,
  input  logic [W-1:0]  src_int,
  output logic          sign,
  output logic          is_zero,
  output logic [LW-1:0] msb_pos,
  output logic [W-1:0]  norm
);
  logic [W-1:0] ext;
  logic [W-1:0] mag;

  always_comb begin
    sign = src_is64 ? src_int[W-1] : src_int[W/2-1];
    ext  = src_is64 ? src_int : {{(W/2){src_int[W/2-1]}}, src_int[W/2-1:0]};
    // unsigned negate keeps the most negative value correct
    mag  = sign ? (~ext + 1'b1) : ext;
    is_zero = (mag == '0);
    msb_pos = '0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) msb_pos = LW'(i);
    end
    norm = mag << (LW'(W - 1) - msb_pos);
  end
endmodule

// File: rtl/cvt_round_pack.sv
module cvt_round_pack
  import cvt_pkg::*;
#(
  parameter int EW = 5,
  parameter int MW = 10,
  parameter int W  = SRC_W,
  localparam int LW   = $clog2(W),
  localparam int G    = W - 2 - MW,
  localparam int BIAS = (1 << (EW - 1)) - 1,
  localparam int EMAX = (1 << EW) - 1
) (
  input  logic          sign,
  input  logic          is_zero,
  input  logic [LW-1:0] msb_pos,
  input  logic [W-1:0]  norm,
  input  logic [1:0]    rnd_mode,
  output logic [63:0]   bits,
  output logic          inexact,
  output logic          overflow
);
  logic [MW:0]   keep;
  logic          guard, sticky, inc, carry, to_inf;
  logic [MW+1:0] sum;
  logic [MW-1:0] frac;
  logic [11:0]   biased;

  always_comb begin
    keep   = norm[W-1 -: MW+1];
    guard  = norm[G];
    sticky = |norm[G-1:0];
    unique case (rmode_e'(rnd_mode))
      RM_NEAR: inc = guard & (sticky | keep[0]);
      RM_PINF: inc = !sign & (guard | sticky);
      RM_NINF: inc = sign & (guard | sticky);
      default: inc = 1'b0;
    endcase
    sum    = {1'b0, keep} + (MW+2)'(inc);
    carry  = sum[MW+1];
    frac   = carry ? '0 : sum[MW-1:0];
    biased = 12'(msb_pos) + 12'(BIAS) + 12'(carry);
    overflow = !is_zero && (biased >= 12'(EMAX));
    to_inf = (rmode_e'(rnd_mode) == RM_NEAR) ||
             (rmode_e'(rnd_mode) == RM_PINF && !sign) ||
             (rmode_e'(rnd_mode) == RM_NINF && sign);
    inexact = !is_zero && (guard || sticky || overflow);
    bits = '0;
    if (is_zero)
      bits = '0;
    else if (overflow)
      bits[EW+MW:0] = to_inf ? {sign, {EW{1'b1}}, {MW{1'b0}}}
                             : {sign, EW'(EMAX - 1), {MW{1'b1}}};
    else
      bits[EW+MW:0] = {sign, biased[EW-1:0], frac};
  end
endmodule

// File: rtl/sint_fp_cvt.sv
module sint_fp_cvt
  import cvt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         src_is64,
  input  logic [1:0]   dst_type,
  input  logic [1:0]   rnd_mode,
  input  logic         merge_en,
  input  logic [63:0]  src_int,
  input  logic [127:0] old_dst,
  output logic         out_valid,
  output logic [127:0] out_result,
  output logic         out_undef,
  output logic         flag_inexact,
  output logic         flag_overflow
);
  localparam int LW = $clog2(SRC_W);

  logic          legal;
  logic [1:0]    fmt_idx;
  logic [6:0]    fmt_width;
  logic          sign, is_zero;
  logic [LW-1:0] msb_pos;
  logic [SRC_W-1:0] norm;
  logic [63:0]   fbits [NFMT];
  logic [NFMT-1:0] f_ix, f_ov;

  logic [DST_W-1:0] nx_result;
  logic nx_undef, nx_ix, nx_ov;

  cvt_decode u_dec (
    .src_is64 (src_is64), .dst_type (dst_type),
    .legal (legal), .fmt_idx (fmt_idx), .fmt_width (fmt_width)
  );

  cvt_normalize #(.W(SRC_W)) u_norm (
    .src_is64 (src_is64), .src_int (src_int),
    .sign (sign), .is_zero (is_zero), .msb_pos (msb_pos), .norm (norm)
  );

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    cvt_round_pack #(.EW(fmt_exp_w(g)), .MW(fmt_man_w(g)), .W(SRC_W)) u_rp (
      .sign (sign), .is_zero (is_zero), .msb_pos (msb_pos), .norm (norm),
      .rnd_mode (rnd_mode), .bits (fbits[g]),
      .inexact (f_ix[g]), .overflow (f_ov[g])
    );
  end

  // next-state
  always_comb begin
    logic [DST_W-1:0] mask;
    mask = (DST_W'(1) << fmt_width) - 1'b1;
    if (!legal) begin
      nx_result = old_dst;
      nx_undef  = 1'b1;
      nx_ix     = 1'b0;
      nx_ov     = 1'b0;
    end else begin
      nx_result = ((merge_en ? old_dst : '0) & ~mask) |
                  (DST_W'(fbits[fmt_idx]) & mask);
      nx_undef  = 1'b0;
      nx_ix     = f_ix[fmt_idx];
      nx_ov     = f_ov[fmt_idx];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_undef     <= 1'b0;
      flag_inexact  <= 1'b0;
      flag_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= nx_result;
        out_undef     <= nx_undef;
        flag_inexact  <= nx_ix;
        flag_overflow <= nx_ov;
      end
    end
  end

  // assertions
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_undef));
  assert_undef_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal) |=> (out_undef && out_result == $past(old_dst)));
  assert_undef_no_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> !flag_inexact && !flag_overflow);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal && fmt_e'(dst_type) != FMT_HLF) |=> !flag_overflow);
  assert_ovf_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> flag_inexact);
  assert_zero_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal && !merge_en && fmt_e'(dst_type) == FMT_HLF)
      |=> out_result[127:16] == '0);
endmodule

// File: tb/sint_fp_cvt_tb.sv
module sint_fp_cvt_tb;
  localparam int NV = 21;
  localparam logic [127:0] OLD_A = {16{8'hA5}};

  // {is64, type, rmode, merge, src[64], expected low[64], ix, ov}
  localparam logic [135:0] VEC [NV] = '{
    {1'b0, 2'b01, 2'b00, 1'b0, 64'h1,                   64'h3FF0000000000000, 2'b00}, // R3
    {1'b0, 2'b11, 2'b00, 1'b1, 64'h00000000FFFFFFFE,    64'hC000,             2'b00}, // R1
    {1'b0, 2'b01, 2'b00, 1'b0, 64'hFFFFFFFF7FFFFFFF,    64'h41DFFFFFFFC00000, 2'b00}, // R1
    {1'b1, 2'b00, 2'b00, 1'b0, 64'h1000001,             64'h4B800000,         2'b10}, // R4
    {1'b1, 2'b00, 2'b01, 1'b0, 64'h1000001,             64'h4B800001,         2'b10}, // R4
    {1'b1, 2'b00, 2'b10, 1'b0, 64'hFFFFFFFFFEFFFFFF,    64'hCB800001,         2'b10}, // R4
    {1'b1, 2'b00, 2'b11, 1'b0, 64'hFFFFFFFFFEFFFFFF,    64'hCB800000,         2'b10}, // R4
    {1'b1, 2'b00, 2'b00, 1'b1, 64'h0,                   64'h0,                2'b00}, // R3
    {1'b1, 2'b00, 2'b00, 1'b0, 64'h8000000000000000,    64'hDF000000,         2'b00}, // R3
    {1'b1, 2'b00, 2'b00, 1'b0, 64'h7FFFFFFFFFFFFFFF,    64'h5F000000,         2'b10}, // R5
    {1'b1, 2'b11, 2'b00, 1'b0, 64'hFFEF,                64'h7BFF,             2'b10}, // R5
    {1'b1, 2'b11, 2'b00, 1'b0, 64'hFFF0,                64'h7C00,             2'b11}, // R6
    {1'b1, 2'b11, 2'b11, 1'b0, 64'hFFF0,                64'h7BFF,             2'b10}, // R6
    {1'b0, 2'b11, 2'b01, 1'b0, 64'hFFFE7960,            64'hFBFF,             2'b11}, // R6
    {1'b0, 2'b11, 2'b10, 1'b0, 64'hFFFE7960,            64'hFC00,             2'b11}, // R6
    {1'b0, 2'b11, 2'b00, 1'b0, 64'h80000000,            64'hFC00,             2'b11}, // R6
    {1'b1, 2'b11, 2'b00, 1'b0, 64'd2049,                64'h6800,             2'b10}, // R4
    {1'b1, 2'b11, 2'b01, 1'b0, 64'd2049,                64'h6801,             2'b10}, // R4
    {1'b1, 2'b11, 2'b11, 1'b0, 64'd3,                   64'h4200,             2'b00}, // R3
    {1'b0, 2'b01, 2'b00, 1'b1, 64'hFFFFFFFF,            64'hBFF0000000000000, 2'b00}, // R7
    {1'b1, 2'b00, 2'b00, 1'b0, 64'h00000000FFFFFFFF,    64'h4F800000,         2'b10}  // R1
  };

  logic clk, rst_n, in_valid, src_is64, merge_en;
  logic [1:0] dst_type, rnd_mode;
  logic [63:0] src_int;
  logic [127:0] old_dst;
  logic out_valid, out_undef, flag_inexact, flag_overflow;
  logic [127:0] out_result;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  sint_fp_cvt u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .src_is64 (src_is64),
    .dst_type (dst_type), .rnd_mode (rnd_mode), .merge_en (merge_en),
    .src_int (src_int), .old_dst (old_dst), .out_valid (out_valid),
    .out_result (out_result), .out_undef (out_undef),
    .flag_inexact (flag_inexact), .flag_overflow (flag_overflow)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic string tag_of(int i);
    case (i)
      0, 7, 8, 18:       return "R3";
      1, 2, 20:          return "R1";
      3, 4, 5, 6, 16, 17: return "R4";
      9, 10:             return "R5";
      19:                return "R7";
      default:           return "R6";
    endcase
  endfunction

  function automatic logic [127:0] expect_word(logic [1:0] t, logic m,
                                               logic [63:0] low, logic [127:0] old);
    int w;
    logic [127:0] mask;
    w = (t == 2'b11) ? 16 : (t == 2'b00) ? 32 : 64;
    mask = (128'd1 << w) - 1;
    return ((m ? old : 128'd0) & ~mask) | ({64'd0, low} & mask);
  endfunction

  task automatic check(string req, logic [131:0] act, logic [131:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (valid,undef,ix,ov,result)", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic s64, logic [1:0] t, logic [1:0] rm, logic m,
                       logic [63:0] src, logic [127:0] old);
    in_valid = v; src_is64 = s64; dst_type = t; rnd_mode = rm;
    merge_en = m; src_int = src; old_dst = old;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; src_is64 = 0; dst_type = 0; rnd_mode = 0;
    merge_en = 0; src_int = 0; old_dst = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {out_valid, out_undef, flag_inexact, flag_overflow, out_result}, '0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      v = VEC[i];
      drive(1'b1, v[135], v[134:133], v[132:131], v[130], v[129:66], OLD_A);
      check(tag_of(i), {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
            {1'b1, 1'b0, v[1], v[0], expect_word(v[134:133], v[130], v[65:2], OLD_A)});
    end

    // R8: hold while in_valid low, valid drops
    drive(1'b1, 1'b1, 2'b11, 2'b00, 1'b0, 64'hFFF0, OLD_A);
    drive(1'b0, 1'b0, 2'b01, 2'b00, 1'b1, 64'h1, ~OLD_A);
    check("R8", {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
          {1'b0, 1'b0, 1'b1, 1'b1, 112'd0, 16'h7C00});

    // R2: unsupported pairings
    drive(1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h5, 128'h0123456789ABCDEF_FEDCBA9876543210);
    check("R2", {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
          {4'b1100, 128'h0123456789ABCDEF_FEDCBA9876543210});
    drive(1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 64'hFFFF, ~OLD_A);
    check("R2", {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
          {4'b1100, ~OLD_A});
    drive(1'b1, 1'b0, 2'b10, 2'b00, 1'b0, 64'h80000000, OLD_A);
    check("R2", {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
          {4'b1100, OLD_A});
    drive(1'b1, 1'b1, 2'b10, 2'b01, 1'b1, 64'h3, 128'd7);
    check("R2", {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
          {4'b1100, 128'd7});
    // R2: legal after illegal clears undef
    drive(1'b1, 1'b1, 2'b11, 2'b00, 1'b0, 64'd1, OLD_A);
    check("R2", {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
          {4'b1000, 112'd0, 16'h3C00});

    // R7: merge with half keeps 112 upper bits
    drive(1'b1, 1'b1, 2'b11, 2'b00, 1'b1, 64'd1, ~OLD_A);
    check("R7", {out_valid, out_undef, flag_inexact, flag_overflow, out_result},
          {4'b1000, expect_word(2'b11, 1'b1, 64'h3C00, ~OLD_A)});

    // R9: reset again clears everything
    in_valid = 0;
    rst_n = 0;
    #1;
    check("R9", {out_valid, out_undef, flag_inexact, flag_overflow, out_result}, '0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule